// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of scatter-gather segments, each a 32-bit bus address with a byte length, into a table of physical region descriptors for a bus-mastering disk controller. Every descriptor is a pair of 32-bit words: the chunk start address, then a count/flags word. Descriptors are written one word per cycle through a plain write port (enable, word index, data). Descriptor n occupies word index 2n (address) and 2n+1 (count).

Segments arrive on a valid/ready stream with a last flag marking the final segment of a table. `seg_ready` is high only while the builder can take a new segment. A segment is held by the producer, with `seg_valid` high and the payload stable, until a clock edge where both are high. After a non-empty segment is taken, `seg_ready` stays low until all of its descriptors are written. The write port has no back-pressure: the table store must accept one word on every cycle where `tbl_we` is high. `alt_fmt` selects the count format. It must stay constant from the first segment of a table until `done`. When the table is finished, the builder raises `done` for one cycle with exactly one of success, overflow or empty. Overflow and empty tell the caller to fall back to programmed I/O for that request.

Top module: `prd_table_builder`

## Requirements
- R1: No descriptor crosses a 64 KB address boundary. A chunk's length is the smaller of the remaining segment length and 0x10000 minus the low 16 bits of its start address.
- R2: Descriptor n is written with its chunk start address at word index 2n and its count word at 2n+1. Nothing is written at or beyond index 2n for an unbuilt descriptor n.
- R3: In standard format (`alt_fmt`=0), bits 15:0 of the count word hold the chunk length and bits 30:16 are zero.
- R4: In standard format, a chunk that would be exactly 0x10000 bytes becomes two descriptors of 0x8000 bytes. The second descriptor starts 0x8000 higher than the first, and both count against the table limit.
- R5: In standard format, bit 31 of the count word is set on the last descriptor of a successful table and on no other.
- R6: In alternate format (`alt_fmt`=1), the count word holds ((length mod 65536) >> 2) − 1, taken mod 65536, in bits 31:16, with bits 15:0 zero. There is no end bit and no 64 KB split, so a 0x10000 chunk encodes as 0xFFFF0000.
- R7: A zero-length segment yields no descriptor. If a zero-length segment carries the last flag after descriptors were built in standard format, the previous count word is rewritten with bit 31 set.
- R8: A table may hold exactly MAX_ENTRIES descriptors. A descriptor that would exceed the limit is not written. Remaining segments are then taken and discarded through the one with the last flag. `done_overflow` is raised and `entry_total` is 0.
- R9: A table that yields no descriptors raises `done_empty` with `entry_total` 0.
- R10: `done` is a single-cycle pulse with exactly one of `done_ok`, `done_overflow` or `done_empty` high. On success, `entry_total` equals the number of descriptors built.
- R11: No descriptor word is written in any cycle where `seg_ready` is high, and each segment is fully processed before the next is taken.
- R12: After reset, `seg_ready` is 1 and `tbl_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_fmt | input | 1 | 0: standard count format, 1: 32-bit-aligned count format |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Builder can take a segment |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the table |
| tbl_we | output | 1 | Descriptor word write strobe |
| tbl_waddr | output | IDX_W | Word index in the table |
| tbl_wdata | output | 32 | Descriptor word |
| done | output | 1 | Table finished (one cycle) |
| done_ok | output | 1 | Table built successfully |
| done_overflow | output | 1 | Table limit exceeded |
| done_empty | output | 1 | No descriptors produced |
| entry_total | output | CNT_W | Descriptors built on success, else 0 |

## Verification
The sweep places segment starts just below, at and just above a 64 KB boundary and at its midpoint, and uses lengths around 32 KB and 64 KB in both formats. A builder that mis-clips a chunk would emit a crossing descriptor. A builder that skipped the full-window split would write a standard count of zero, and one that split in alternate format would give two entries where one is expected. Tables that fill the limit exactly and tables one descriptor over it separate an off-by-one overflow test from a correct one. An overflow in a segment that is not last checks that the trailing segments are drained. Zero-length segments placed first, in the middle and last catch a missing end bit, a spurious descriptor or a wrong empty verdict.

// File: rtl/prd_gen_pkg.sv
package prd_gen_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [16:0] WIN_BYTES = 17'h10000;
  localparam logic [16:0] HALF_WIN  = 17'h08000;
  localparam int unsigned END_BIT = 31;

  typedef enum logic [2:0] {
    ST_TAKE, ST_ADDR, ST_CNT, ST_PATCH, ST_DRAIN, ST_DONE
  } prd_state_e;

  typedef enum logic [1:0] {
    RES_NONE, RES_OK, RES_OVF, RES_EMPTY
  } prd_result_e;
endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
  import prd_gen_pkg::*;
#(
  parameter int unsigned LEN_W = 32
) (
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic              alt_fmt,
  input  logic              final_seg,
  output logic [16:0]       chunk,
  output logic              seg_end,
  output logic [WORD_W-1:0] cnt_word
);
  logic [16:0] to_bnd;
  logic [16:0] raw;
  logic [15:0] alt_q;

  always_comb begin
    // distance to the next 64 KB window edge
    to_bnd = WIN_BYTES - {1'b0, cur_addr[15:0]};
    raw    = (remain >= LEN_W'(to_bnd)) ? to_bnd : remain[16:0];
    // standard format cannot encode a full window: halve it
    chunk  = (!alt_fmt && raw == WIN_BYTES) ? HALF_WIN : raw;
    seg_end = (remain == LEN_W'(chunk));
    alt_q  = {2'b00, chunk[15:2]} - 16'd1;
    if (alt_fmt) cnt_word = {alt_q, 16'h0000};
    else         cnt_word = {final_seg && seg_end, 15'd0, chunk[15:0]};
  end
endmodule

// File: rtl/prd_slot_tracker.sv
module prd_slot_tracker #(
  parameter int unsigned MAX_ENTRIES = 256,
  parameter int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
  parameter int unsigned IDX_W = $clog2(2 * MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] used,
  output logic             full,
  output logic [IDX_W-1:0] addr_idx,
  output logic [IDX_W-1:0] cnt_idx,
  output logic [IDX_W-1:0] prev_cnt_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) used <= '0;
    else if (bump)       used <= used + 1'b1;
  end

  always_comb begin
    full         = (used == CNT_W'(MAX_ENTRIES));
    addr_idx     = IDX_W'({used, 1'b0});
    cnt_idx      = addr_idx | IDX_W'(1);
    prev_cnt_idx = addr_idx - IDX_W'(1);
  end
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder
  import prd_gen_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 256,
  parameter int unsigned LEN_W = 32,
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int unsigned IDX_W = $clog2(2 * MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_fmt,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr,
  output logic [31:0]       tbl_wdata,
  output logic              done,
  output logic              done_ok,
  output logic              done_overflow,
  output logic              done_empty,
  output logic [CNT_W-1:0]  entry_total
);
  prd_state_e  state;
  prd_result_e result;
  logic [WORD_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              seg_fin;
  logic [WORD_W-1:0] last_cnt_word;

  logic [16:0]       chunk;
  logic              seg_end;
  logic [WORD_W-1:0] cnt_word;
  logic [CNT_W-1:0]  used;
  logic              full;
  logic [IDX_W-1:0]  addr_idx, cnt_idx, prev_cnt_idx;
  logic              take;

  prd_chunk_calc #(.LEN_W(LEN_W)) u_calc (
    .cur_addr  (cur_addr),
    .remain    (remain),
    .alt_fmt   (alt_fmt),
    .final_seg (seg_fin),
    .chunk     (chunk),
    .seg_end   (seg_end),
    .cnt_word  (cnt_word)
  );

  prd_slot_tracker #(.MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (state == ST_DONE),
    .bump         (state == ST_CNT),
    .used         (used),
    .full         (full),
    .addr_idx     (addr_idx),
    .cnt_idx      (cnt_idx),
    .prev_cnt_idx (prev_cnt_idx)
  );

  always_comb begin
    seg_ready = (state == ST_TAKE) || (state == ST_DRAIN);
    take      = seg_valid && seg_ready;
    tbl_we    = 1'b0;
    tbl_waddr = '0;
    tbl_wdata = '0;
    case (state)
      ST_ADDR: begin
        tbl_we    = !full;
        tbl_waddr = addr_idx;
        tbl_wdata = cur_addr;
      end
      ST_CNT: begin
        tbl_we    = 1'b1;
        tbl_waddr = cnt_idx;
        tbl_wdata = cnt_word;
      end
      ST_PATCH: begin
        tbl_we    = 1'b1;
        tbl_waddr = prev_cnt_idx;
        tbl_wdata = last_cnt_word | (WORD_W'(1) << END_BIT);
      end
      default: ;
    endcase
    done          = (state == ST_DONE);
    done_ok       = done && (result == RES_OK);
    done_overflow = done && (result == RES_OVF);
    done_empty    = done && (result == RES_EMPTY);
    entry_total   = done_ok ? used : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_TAKE;
      result        <= RES_NONE;
      cur_addr      <= '0;
      remain        <= '0;
      seg_fin       <= 1'b0;
      last_cnt_word <= '0;
    end else begin
      case (state)
        ST_TAKE: if (take) begin
          if (seg_len == '0) begin
            if (seg_last) begin
              if (used == '0) begin
                result <= RES_EMPTY;
                state  <= ST_DONE;
              end else if (!alt_fmt) begin
                state  <= ST_PATCH;
              end else begin
                result <= RES_OK;
                state  <= ST_DONE;
              end
            end
          end else begin
            cur_addr <= seg_addr;
            remain   <= seg_len;
            seg_fin  <= seg_last;
            state    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (full) begin
            result <= RES_OVF;
            state  <= seg_fin ? ST_DONE : ST_DRAIN;
          end else begin
            state  <= ST_CNT;
          end
        end
        ST_CNT: begin
          last_cnt_word <= cnt_word;
          cur_addr      <= cur_addr + WORD_W'(chunk);
          remain        <= remain - LEN_W'(chunk);
          if (seg_end) begin
            if (seg_fin) begin
              result <= RES_OK;
              state  <= ST_DONE;
            end else begin
              state  <= ST_TAKE;
            end
          end else begin
            state <= ST_ADDR;
          end
        end
        ST_PATCH: begin
          result <= RES_OK;
          state  <= ST_DONE;
        end
        ST_DRAIN: if (take && seg_last) state <= ST_DONE;
        ST_DONE:  state <= ST_TAKE;
        default:  state <= ST_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/prd_table_builder_checks.sv
module prd_table_builder_checks #(
  parameter int unsigned MAX_ENTRIES = 256,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alt_fmt,
  input logic             seg_ready,
  input logic             tbl_we,
  input logic [IDX_W-1:0] tbl_waddr,
  input logic [31:0]      tbl_wdata,
  input logic             done,
  input logic             done_ok,
  input logic             done_overflow,
  input logic             done_empty,
  input logic [CNT_W-1:0] entry_total
);
  assert_no_cross_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !tbl_waddr[0] && !alt_fmt) |=>
      (tbl_we && tbl_waddr[0] &&
       ({1'b0, $past(tbl_wdata[15:0])} + {1'b0, tbl_wdata[15:0]}) <= 17'h10000));

  assert_std_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_waddr[0] && !alt_fmt) |-> (tbl_wdata[30:16] == 15'd0));

  assert_no_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_waddr[0] && !alt_fmt) |-> (tbl_wdata[15:0] != 16'd0));

  assert_alt_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_waddr[0] && alt_fmt) |-> (tbl_wdata[15:0] == 16'd0));

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (int'(tbl_waddr) < 2 * MAX_ENTRIES));

  assert_fail_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |-> (entry_total == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({done_ok, done_overflow, done_empty}) == 1));

  assert_ok_total_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (entry_total != '0));

  assert_quiet_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_ready |-> !tbl_we);
endmodule

bind prd_table_builder prd_table_builder_checks #(
  .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_fmt(alt_fmt), .seg_ready(seg_ready),
  .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
  .done(done), .done_ok(done_ok), .done_overflow(done_overflow),
  .done_empty(done_empty), .entry_total(entry_total)
);

// File: tb/sim_prd_table_builder.sv
`timescale 1ns/1ps
module sim_prd_table_builder;
  localparam int MAX   = 6;
  localparam int CNT_W = $clog2(MAX + 1);
  localparam int IDX_W = $clog2(2 * MAX);
  localparam logic [31:0] SENT = 32'hA5A5_5A5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, alt_fmt, seg_valid, seg_ready, seg_last;
  logic [31:0] seg_addr, tbl_wdata;
  logic [31:0] seg_len;
  logic tbl_we, done, done_ok, done_overflow, done_empty;
  logic [IDX_W-1:0] tbl_waddr;
  logic [CNT_W-1:0] entry_total;

  prd_table_builder #(.MAX_ENTRIES(MAX), .LEN_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .alt_fmt(alt_fmt),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .done(done), .done_ok(done_ok), .done_overflow(done_overflow),
    .done_empty(done_empty), .entry_total(entry_total)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] cap [0:2*MAX-1];
  bit got_done, got_ok, got_ovf, got_emp;
  logic [CNT_W-1:0] got_total;
  logic [31:0] sa [0:7];
  logic [31:0] sl [0:7];
  int nseg;
  bit wd;

  task automatic chk(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (tbl_we) cap[tbl_waddr] = tbl_wdata;
    if (done) begin
      got_done  = 1'b1;
      got_ok    = done_ok;
      got_ovf   = done_overflow;
      got_emp   = done_empty;
      got_total = entry_total;
    end
  endtask

  task automatic send(logic [31:0] a, logic [31:0] l, bit last);
    bit acc;
    seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last;
    forever begin
      acc = seg_ready;
      tick();
      if (acc) break;
    end
    seg_valid = 1'b0;
  endtask

  task automatic run_table(bit alt, string tag);
    logic [31:0] ew [0:2*MAX-1];
    int cnt, lim;
    bit ovf;
    logic [31:0] a, r, b;
    for (int k = 0; k < 2*MAX; k++) begin cap[k] = SENT; ew[k] = SENT; end
    got_done = 1'b0;
    alt_fmt = alt;
    for (int i = 0; i < nseg; i++) send(sa[i], sl[i], i == nseg - 1);
    for (int k = 0; k < 200 && !got_done; k++) tick();
    // expected table from the requirements
    cnt = 0; ovf = 1'b0;
    for (int i = 0; i < nseg; i++) begin
      a = sa[i]; r = sl[i];
      while (r != 0 && !ovf) begin
        b = 32'h10000 - {16'h0, a[15:0]};
        if (b > r) b = r;
        if (!alt && b == 32'h10000) b = 32'h8000;     // R4 split
        if (cnt == MAX) ovf = 1'b1;
        else begin
          ew[2*cnt]   = a;
          ew[2*cnt+1] = alt ? {(b[15:0] >> 2) - 16'd1, 16'h0000} : {16'h0000, b[15:0]};
          cnt++; a = a + b; r = r - b;
        end
      end
    end
    if (!ovf && !alt && cnt > 0) ew[2*cnt-1][31] = 1'b1; // R5 / R7
    chk(got_done, {tag, " R10 done seen"}, 32'(got_done), 1);
    chk(got_ovf == ovf, {tag, " R8 overflow flag"}, 32'(got_ovf), 32'(ovf));
    chk(got_emp == (!ovf && cnt == 0), {tag, " R9 empty flag"}, 32'(got_emp), 32'(!ovf && cnt == 0));
    chk(got_ok == (!ovf && cnt > 0), {tag, " R10 ok flag"}, 32'(got_ok), 32'(!ovf && cnt > 0));
    chk(32'(got_total) == ((!ovf) ? cnt : 0), {tag, " R10 entry total"}, 32'(got_total), (!ovf) ? cnt : 0);
    lim = ovf ? 2*MAX : 2*cnt + ((cnt < MAX) ? 1 : 0);
    for (int k = 0; k < lim; k++)
      chk(cap[k] == ew[k], $sformatf("%s R2 word %0d", tag, k), cap[k], ew[k]);
  endtask

  task automatic one(logic [31:0] a, logic [31:0] l, bit alt, string tag);
    nseg = 1; sa[0] = a; sl[0] = l;
    run_table(alt, tag);
  endtask

  task automatic run_all();
    logic [31:0] offs [0:5];
    logic [31:0] lens [0:6];
    rst_n = 1'b0; alt_fmt = 1'b0; seg_valid = 1'b0;
    seg_addr = '0; seg_len = '0; seg_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(seg_ready == 1'b1, "R12 ready in reset", 32'(seg_ready), 1);
    rst_n = 1'b1;
    tick();
    chk(seg_ready == 1'b1 && !tbl_we && !done, "R12 idle after reset",
        {29'd0, seg_ready, tbl_we, done}, 32'h4);

    one(32'h1000_0100, 32'h200, 1'b0, "R3 small");
    one(32'h0001_FF00, 32'h300, 1'b0, "R1 crossing");
    one(32'h0002_0000, 32'h10000, 1'b0, "R4 full window");
    one(32'h0002_0000, 32'h10000, 1'b1, "R6 full window alt");
    one(32'h0002_0010, 32'h40, 1'b1, "R6 small alt");
    one(32'h0004_0000, 32'h30000, 1'b0, "R8 exactly full");
    one(32'h0004_0000, 32'h30004, 1'b0, "R8 one over");

    nseg = 3; sa[0] = 32'h0004_0000; sl[0] = 32'h40000;
    sa[1] = 32'h0009_0000; sl[1] = 32'h100; sa[2] = 32'h000A_0000; sl[2] = 32'h80;
    run_table(1'b0, "R8 drain");

    nseg = 2; sa[0] = 32'h0000_1000; sl[0] = 32'h10; sa[1] = 32'h0; sl[1] = 32'h0;
    run_table(1'b0, "R7 zero last std");
    run_table(1'b1, "R7 zero last alt");

    nseg = 3; sa[0] = 32'h5; sl[0] = 32'h0; sa[1] = 32'h0000_FFF0; sl[1] = 32'h20;
    sa[2] = 32'h9; sl[2] = 32'h0;
    run_table(1'b0, "R7 zero around");

    nseg = 2; sa[0] = 32'h1; sl[0] = 32'h0; sa[1] = 32'h2; sl[1] = 32'h0;
    run_table(1'b0, "R9 empty");

    nseg = 3; sa[0] = 32'h0003_8000; sl[0] = 32'h8000; sa[1] = 32'h0006_FFFC; sl[1] = 32'h8;
    sa[2] = 32'h0007_0000; sl[2] = 32'h10000;
    run_table(1'b0, "R11 multi seg");

    offs = '{32'h0, 32'h2, 32'h7FFC, 32'h8000, 32'hFFFC, 32'hFFFE};
    lens = '{32'h4, 32'h100, 32'h8000, 32'hFFFC, 32'h10000, 32'h10004, 32'h20000};
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 7; j++)
          one(32'h0030_0000 + offs[i], lens[j], m[0], "R1 sweep");
  endtask

  initial begin
    wd = 1'b0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    if (wd) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule